// File: doc/BRIEF.md
# Serial Flash Identification Probe

This block identifies a serial flash device without software help. After a start pulse it drives its own SPI master and sends the read-ID command. It then takes three or four reply bytes, the count being picked by a mode input, and splits them into a manufacturer code and a model code. A leading 0x7F byte is an extended-vendor continuation code, and it widens the manufacturer field to two bytes. The vendor bytes are checked for odd parity. A parity fault is flagged but does not stop the probe.

A device can answer the read-ID command with nothing but ones. In that case the probe falls back to the older electronic-signature command and takes the single byte it returns as the model code. The decoded codes are compared with expected values on the inputs. A wildcard model value accepts any model from the right vendor. When the codes match, one more command reads the device status byte. A one-cycle done pulse closes the probe, and the verdict and flags are valid on that pulse.

Top module: `flash_id_probe`

## Requirements
- R1: A probe opens with opcode 0x9F sent MSB first in SPI mode 0 (clock idle low, data sampled on the rising edge), with chip select low for the whole command. It is followed by 4 reply bytes when `four_byte` is 1 and 3 when it is 0, so 32 or 40 clock pulses in total.
- R2: When reply byte 0 is not 0x7F, `manuf_id` is {8'h00, byte0} and `model_id` is {byte1, byte2}. Byte 3, if read, is ignored.
- R3: When reply byte 0 is 0x7F, `manuf_id` is {byte0, byte1}. `model_id` is {8'h00, byte2} in 3-byte mode and {byte2, byte3} in 4-byte mode.
- R4: `parity_warn` is 1 when byte0 has an even number of ones, or when the continuation case applies and byte1 has an even number of ones. The probe still completes and reaches its verdict.
- R5: On the read-ID path, a match needs `manuf_id` equal to `exp_manuf` and either `model_id` equal to `exp_model` or `exp_model` equal to the parameter `GENERIC_MODEL` (default 16'hFFFF).
- R6: When reply bytes 0, 1 and 2 are all 0xFF, a second command follows: opcode 0xAB, three 0x00 bytes, then one reply byte (40 clock pulses). In that case `manuf_id` is 0, `model_id` is {8'h00, reply}, a match needs `model_id` to equal `exp_model` exactly (no wildcard), `legacy_used` is 1 and `parity_warn` is 0.
- R7: After a match, a read-status command is sent: opcode 0x05 and one reply byte (16 clock pulses), and that byte appears on `status_byte`. On a no-match no such command is sent and `status_byte` is 0.
- R8: Between two commands chip select stays high for at least two SPI clock periods (4*CLK_DIV system clocks), and the SPI clock stays low whenever chip select is high.
- R9: `done` is a single-cycle pulse. On it exactly one of `id_match` and `id_nomatch` is 1 and chip select is high. The verdict outputs hold until the next start. A start pulse during a probe is ignored.
- R10: After reset, chip select is high, the SPI clock is low, and `done`, `busy`, both verdict flags, `parity_warn`, `legacy_used`, `status_byte` and the ID outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a probe |
| four_byte | input | 1 | 1: read four ID bytes, 0: read three |
| exp_manuf | input | 16 | Expected manufacturer code |
| exp_model | input | 16 | Expected model code, or GENERIC_MODEL as wildcard |
| spi_miso | input | 1 | Serial data from the device |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| busy | output | 1 | A probe is running |
| done | output | 1 | One-cycle end-of-probe pulse |
| id_match | output | 1 | Device identified as expected |
| id_nomatch | output | 1 | Device did not match |
| parity_warn | output | 1 | Vendor byte parity fault seen |
| legacy_used | output | 1 | Signature fallback was taken |
| manuf_id | output | 16 | Decoded manufacturer code |
| model_id | output | 16 | Decoded model code |
| status_byte | output | 8 | Device status read after a match |

## Verification
The bench builds the probe with CLK_DIV set to 2 and the default wildcard of 16'hFFFF. A full probe then costs only a few hundred system clocks. That makes it affordable to sweep every value of the first reply byte in 3-byte mode, which covers both parity outcomes, the continuation code and all four verdict choices. It also sweeps every value of the second reply byte behind a 0x7F prefix in 4-byte mode. Directed probes cover the all-ones fallback in both modes, with and without a match, and a start pulse sent in the middle of a probe.

// File: rtl/flash_probe_pkg.sv
`timescale 1ns/1ps
package flash_probe_pkg;

    localparam int ID_W = 16;

    localparam logic [7:0] OP_READ_ID     = 8'h9F;
    localparam logic [7:0] OP_LEGACY_SIG  = 8'hAB;
    localparam logic [7:0] OP_READ_STATUS = 8'h05;
    localparam logic [7:0] CONT_CODE      = 8'h7F;

    typedef enum logic [1:0] {
        CMD_ID,
        CMD_SIG,
        CMD_STAT
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_WAIT,
        ST_GAP,
        ST_DECIDE,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic [ID_W-1:0] manuf;
        logic [ID_W-1:0] model;
        logic            par_warn;
        logic            all_ones;
    } id_info_t;

    function automatic logic parity_is_odd(input logic [7:0] b);
        return ^b;
    endfunction

    function automatic logic [7:0] opcode_of(input cmd_e c);
        case (c)
            CMD_ID:  return OP_READ_ID;
            CMD_SIG: return OP_LEGACY_SIG;
            default: return OP_READ_STATUS;
        endcase
    endfunction

    // index of the final byte in a command frame (opcode is index 0)
    function automatic logic [2:0] last_index(input cmd_e c, input logic four);
        case (c)
            CMD_ID:  return four ? 3'd4 : 3'd3;
            CMD_SIG: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_xfer.sv
`timescale 1ns/1ps
module spi_byte_xfer #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic          active;
    logic          phase_hi;
    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;

    assign mosi    = sh_tx[7];
    assign rx_byte = sh_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            phase_hi  <= 1'b0;
            div_cnt   <= '0;
            bit_cnt   <= '0;
            sh_tx     <= '0;
            sh_rx     <= '0;
            sck       <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active   <= 1'b1;
                    phase_hi <= 1'b0;
                    div_cnt  <= '0;
                    bit_cnt  <= '0;
                    sh_tx    <= tx_byte;
                end
            end else if (div_cnt == DW'(CLK_DIV - 1)) begin
                div_cnt <= '0;
                if (!phase_hi) begin
                    sck      <= 1'b1;
                    phase_hi <= 1'b1;
                    sh_rx    <= {sh_rx[6:0], miso};
                end else begin
                    sck      <= 1'b0;
                    phase_hi <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        sh_tx   <= {sh_tx[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end
endmodule

// File: rtl/id_decode.sv
`timescale 1ns/1ps
module id_decode
    import flash_probe_pkg::*;
(
    input  logic [3:0][7:0] reply,
    input  logic            four_byte,
    output id_info_t        info
);
    logic cont;

    always_comb begin
        cont          = (reply[0] == CONT_CODE);
        info.all_ones = (reply[0] == 8'hFF) && (reply[1] == 8'hFF) && (reply[2] == 8'hFF);
        info.par_warn = !parity_is_odd(reply[0]) || (cont && !parity_is_odd(reply[1]));
        if (cont) begin
            info.manuf = {reply[0], reply[1]};
            info.model = four_byte ? {reply[2], reply[3]} : {8'h00, reply[2]};
        end else begin
            info.manuf = {8'h00, reply[0]};
            info.model = {reply[1], reply[2]};
        end
    end
endmodule

// File: rtl/probe_ctrl.sv
`timescale 1ns/1ps
module probe_ctrl
    import flash_probe_pkg::*;
#(
    parameter int              CLK_DIV       = 4,
    parameter logic [ID_W-1:0] GENERIC_MODEL = 16'hFFFF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            four_byte,
    input  logic [ID_W-1:0] exp_manuf,
    input  logic [ID_W-1:0] exp_model,
    input  id_info_t        id,
    input  logic            byte_done,
    input  logic [7:0]      rx_byte,
    output logic            byte_go,
    output logic [7:0]      tx_byte,
    output logic            cs_n,
    output logic [3:0][7:0] reply,
    output logic            four_q,
    output logic            busy,
    output logic            done,
    output logic            id_match,
    output logic            id_nomatch,
    output logic            parity_warn,
    output logic            legacy_used,
    output logic [ID_W-1:0] manuf_id,
    output logic [ID_W-1:0] model_id,
    output logic [7:0]      status_byte
);
    localparam int GAP_CYC = 4 * CLK_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);

    state_e          state;
    cmd_e            cmd;
    logic [2:0]      idx;
    logic [GW-1:0]   gap_cnt;
    logic [7:0]      sig_q;
    logic            matched;
    logic            id_hit;
    logic            sig_hit;
    logic [ID_W-1:0] sig_model;

    assign busy      = (state != ST_IDLE);
    assign sig_model = {8'h00, sig_q};
    assign id_hit    = (id.manuf == exp_manuf) &&
                       ((id.model == exp_model) || (exp_model == GENERIC_MODEL));
    assign sig_hit   = (sig_model == exp_model);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cmd         <= CMD_ID;
            idx         <= '0;
            gap_cnt     <= '0;
            sig_q       <= '0;
            matched     <= 1'b0;
            byte_go     <= 1'b0;
            tx_byte     <= '0;
            cs_n        <= 1'b1;
            reply       <= '0;
            four_q      <= 1'b0;
            done        <= 1'b0;
            id_match    <= 1'b0;
            id_nomatch  <= 1'b0;
            parity_warn <= 1'b0;
            legacy_used <= 1'b0;
            manuf_id    <= '0;
            model_id    <= '0;
            status_byte <= '0;
        end else begin
            byte_go <= 1'b0;
            done    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        four_q      <= four_byte;
                        id_match    <= 1'b0;
                        id_nomatch  <= 1'b0;
                        parity_warn <= 1'b0;
                        legacy_used <= 1'b0;
                        manuf_id    <= '0;
                        model_id    <= '0;
                        status_byte <= '0;
                        matched     <= 1'b0;
                        cmd         <= CMD_ID;
                        idx         <= '0;
                        cs_n        <= 1'b0;
                        state       <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    byte_go <= 1'b1;
                    tx_byte <= (idx == 3'd0) ? opcode_of(cmd) : 8'h00;
                    state   <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (byte_done) begin
                        case (cmd)
                            CMD_ID:  if (idx != 3'd0) reply[idx[1:0] - 2'd1] <= rx_byte;
                            CMD_SIG: if (idx == 3'd4) sig_q <= rx_byte;
                            default: if (idx == 3'd1) status_byte <= rx_byte;
                        endcase
                        if (idx == last_index(cmd, four_q)) begin
                            cs_n    <= 1'b1;
                            gap_cnt <= '0;
                            state   <= ST_GAP;
                        end else begin
                            idx   <= idx + 3'd1;
                            state <= ST_SHIFT;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GW'(GAP_CYC - 1)) begin
                        state <= ST_DECIDE;
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                ST_DECIDE: begin
                    idx <= '0;
                    case (cmd)
                        CMD_ID: begin
                            if (id.all_ones) begin
                                legacy_used <= 1'b1;
                                cmd         <= CMD_SIG;
                                cs_n        <= 1'b0;
                                state       <= ST_SHIFT;
                            end else begin
                                manuf_id    <= id.manuf;
                                model_id    <= id.model;
                                parity_warn <= id.par_warn;
                                if (id_hit) begin
                                    matched <= 1'b1;
                                    cmd     <= CMD_STAT;
                                    cs_n    <= 1'b0;
                                    state   <= ST_SHIFT;
                                end else begin
                                    state <= ST_FINISH;
                                end
                            end
                        end
                        CMD_SIG: begin
                            manuf_id <= '0;
                            model_id <= sig_model;
                            if (sig_hit) begin
                                matched <= 1'b1;
                                cmd     <= CMD_STAT;
                                cs_n    <= 1'b0;
                                state   <= ST_SHIFT;
                            end else begin
                                state <= ST_FINISH;
                            end
                        end
                        default: state <= ST_FINISH;
                    endcase
                end
                ST_FINISH: begin
                    done       <= 1'b1;
                    id_match   <= matched;
                    id_nomatch <= !matched;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_id_probe.sv
`timescale 1ns/1ps
module flash_id_probe
    import flash_probe_pkg::*;
#(
    parameter int              CLK_DIV       = 4,
    parameter logic [ID_W-1:0] GENERIC_MODEL = 16'hFFFF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            four_byte,
    input  logic [ID_W-1:0] exp_manuf,
    input  logic [ID_W-1:0] exp_model,
    input  logic            spi_miso,
    output logic            spi_sck,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    output logic            busy,
    output logic            done,
    output logic            id_match,
    output logic            id_nomatch,
    output logic            parity_warn,
    output logic            legacy_used,
    output logic [ID_W-1:0] manuf_id,
    output logic [ID_W-1:0] model_id,
    output logic [7:0]      status_byte
);
    logic            byte_go;
    logic            byte_done;
    logic [7:0]      tx_byte;
    logic [7:0]      rx_byte;
    logic [3:0][7:0] reply;
    logic            four_q;
    id_info_t        id_info;

    spi_byte_xfer #(.CLK_DIV(CLK_DIV)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .go        (byte_go),
        .tx_byte   (tx_byte),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    id_decode u_decode (
        .reply     (reply),
        .four_byte (four_q),
        .info      (id_info)
    );

    probe_ctrl #(
        .CLK_DIV       (CLK_DIV),
        .GENERIC_MODEL (GENERIC_MODEL)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .four_byte   (four_byte),
        .exp_manuf   (exp_manuf),
        .exp_model   (exp_model),
        .id          (id_info),
        .byte_done   (byte_done),
        .rx_byte     (rx_byte),
        .byte_go     (byte_go),
        .tx_byte     (tx_byte),
        .cs_n        (spi_cs_n),
        .reply       (reply),
        .four_q      (four_q),
        .busy        (busy),
        .done        (done),
        .id_match    (id_match),
        .id_nomatch  (id_nomatch),
        .parity_warn (parity_warn),
        .legacy_used (legacy_used),
        .manuf_id    (manuf_id),
        .model_id    (model_id),
        .status_byte (status_byte)
    );
endmodule

// File: rtl/flash_id_probe_chk.sv
`timescale 1ns/1ps
module flash_id_probe_chk #(
    parameter int CLK_DIV = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       done,
    input logic       id_match,
    input logic       id_nomatch,
    input logic       parity_warn,
    input logic       legacy_used,
    input logic [7:0] status_byte
);
    localparam int MIN_GAP = 4 * CLK_DIV;

    logic [15:0] hi_cnt;
    logic        armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            armed  <= 1'b0;
        end else begin
            if (spi_cs_n) begin
                if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
            end else begin
                hi_cnt <= '0;
                armed  <= 1'b1;
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (id_match != id_nomatch));

    // R9
    done_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_cs_n);

    // R8
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $fell(spi_cs_n)) |-> (hi_cnt >= 16'(MIN_GAP)));

    // R6
    legacy_no_warn_chk: assert property (@(posedge clk) disable iff (rst)
        (done && legacy_used) |-> !parity_warn);

    // R7
    status_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && id_nomatch) |-> (status_byte == 8'h00));
endmodule

bind flash_id_probe flash_id_probe_chk #(.CLK_DIV(CLK_DIV)) u_probe_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_sck     (spi_sck),
    .done        (done),
    .id_match    (id_match),
    .id_nomatch  (id_nomatch),
    .parity_warn (parity_warn),
    .legacy_used (legacy_used),
    .status_byte (status_byte)
);

// File: tb/tb_flash_id_probe.sv
`timescale 1ns/1ps
module tb_flash_id_probe;
    localparam int          CLK_DIV = 2;
    localparam logic [15:0] GEN     = 16'hFFFF;
    localparam longint      MIN_GAP_NS = 4 * CLK_DIV * 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        four_byte;
    logic [15:0] exp_manuf;
    logic [15:0] exp_model;
    logic        spi_miso;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        busy, done, id_match, id_nomatch, parity_warn, legacy_used;
    logic [15:0] manuf_id, model_id;
    logic [7:0]  status_byte;

    always #10 clk = ~clk;

    flash_id_probe #(.CLK_DIV(CLK_DIV), .GENERIC_MODEL(GEN)) dut (
        .clk(clk), .rst(rst), .start(start), .four_byte(four_byte),
        .exp_manuf(exp_manuf), .exp_model(exp_model), .spi_miso(spi_miso),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .busy(busy), .done(done), .id_match(id_match), .id_nomatch(id_nomatch),
        .parity_warn(parity_warn), .legacy_used(legacy_used),
        .manuf_id(manuf_id), .model_id(model_id), .status_byte(status_byte)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] mb [4];
    logic [7:0] sig_v;
    logic [7:0] stat_v;

    int         nbits = 0;
    logic [7:0] in_sh = 8'h00;
    logic [7:0] cur_op = 8'h00;
    int         op_cnt = 0;
    logic [7:0] op_log [16];
    int         len_log [16];
    int         addr_bad = 0;
    int         gap_viol = 0;
    longint     rise_t = 0;

    function automatic logic [7:0] reply_byte(input logic [7:0] op, input int k);
        case (op)
            8'h9F:   return (k < 4) ? mb[k] : 8'hFF;
            8'hAB:   return (k >= 3) ? sig_v : 8'h00;
            8'h05:   return stat_v;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge spi_cs_n) begin
        rise_t = $time;
        if (op_cnt > 0) len_log[(op_cnt - 1) % 16] = nbits;
    end

    always @(negedge spi_cs_n or posedge spi_sck) begin
        if (spi_sck) begin
            in_sh = {in_sh[6:0], spi_mosi};
            nbits++;
            if (nbits == 8) begin
                cur_op = in_sh;
                op_log[op_cnt % 16] = in_sh;
                op_cnt++;
            end else if ((nbits % 8 == 0) && (cur_op == 8'hAB) && (nbits <= 32)) begin
                if (in_sh != 8'h00) addr_bad++;
            end
        end else begin
            if (rise_t > 0 && ($time - rise_t) < MIN_GAP_NS) gap_viol++;
            nbits  = 0;
            cur_op = 8'h00;
        end
    end

    always @(negedge spi_sck) begin
        if (nbits >= 8) begin
            automatic int k = (nbits - 8) / 8;
            automatic int b = 7 - ((nbits - 8) % 8);
            automatic logic [7:0] rb = reply_byte(cur_op, k);
            spi_miso = rb[b];
        end
    end

    // ---------------- expected values from the requirements ----------------
    logic [15:0] e_manuf, e_model;
    logic        e_match, e_warn, e_legacy;
    logic [7:0]  e_status;
    int          e_nops;
    logic [7:0]  e_ops [3];
    int          e_lens [3];

    task automatic compute_expect(input logic [7:0] b0, b1, b2, b3, input logic four,
                                  input logic [15:0] em, emod, input logic [7:0] sg, st);
        logic cont;
        e_ops[0]  = 8'h9F;
        e_lens[0] = four ? 40 : 32;
        if (b0 == 8'hFF && b1 == 8'hFF && b2 == 8'hFF) begin
            e_legacy = 1'b1;
            e_warn   = 1'b0;
            e_manuf  = 16'h0000;
            e_model  = {8'h00, sg};
            e_match  = (e_model == emod);
            e_ops[1] = 8'hAB; e_lens[1] = 40;
            e_nops   = 2;
        end else begin
            cont     = (b0 == 8'h7F);
            e_legacy = 1'b0;
            e_manuf  = cont ? {b0, b1} : {8'h00, b0};
            e_model  = cont ? (four ? {b2, b3} : {8'h00, b2}) : {b1, b2};
            e_warn   = !(^b0) || (cont && !(^b1));
            e_match  = (e_manuf == em) && ((e_model == emod) || (emod == GEN));
            e_nops   = 1;
        end
        if (e_match) begin
            e_ops[e_nops]  = 8'h05;
            e_lens[e_nops] = 16;
            e_nops++;
        end
        e_status = e_match ? st : 8'h00;
    endtask

    task automatic probe(input logic [7:0] b0, b1, b2, b3, input logic four,
                         input logic [15:0] em, emod, input logic [7:0] sg, st,
                         input bit poke);
        int base;
        int ab0;
        int gv0;
        bit got;
        compute_expect(b0, b1, b2, b3, four, em, emod, sg, st);
        mb[0] = b0; mb[1] = b1; mb[2] = b2; mb[3] = b3;
        sig_v = sg; stat_v = st;
        base = op_cnt; ab0 = addr_bad; gv0 = gap_viol;
        @(negedge clk);
        four_byte = four; exp_manuf = em; exp_model = emod;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got = 0;
        for (int i = 0; i < 4000; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        check("R9 done seen", got, 1'b1);
        check("R5 id_match", id_match, e_match);
        check("R9 id_nomatch", id_nomatch, !e_match);
        check("R2/R3 manuf_id", manuf_id, e_manuf);
        check("R2/R3 model_id", model_id, e_model);
        check("R4 parity_warn", parity_warn, e_warn);
        check("R6 legacy_used", legacy_used, e_legacy);
        check("R7 status_byte", status_byte, e_status);
        check("R8 cs high at done", spi_cs_n, 1'b1);
        check("R1 command count", op_cnt - base, e_nops);
        for (int i = 0; i < 3; i++) begin
            if (i < e_nops && (op_cnt - base) == e_nops) begin
                check("R1 opcode", op_log[(base + i) % 16], e_ops[i]);
                check("R1 frame length", len_log[(base + i) % 16], e_lens[i]);
            end
        end
        check("R6 signature address zero", addr_bad - ab0, 0);
        check("R8 chip select gap", gap_viol - gv0, 0);
        @(negedge clk);
        check("R9 done single cycle", done, 1'b0);
        check("R9 verdict held", id_match, e_match);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL R9 watchdog expired: actual hung expected finish");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0]  c1, c2;
        logic [15:0] mm, md;
        rst = 1'b1; start = 1'b0; four_byte = 1'b0;
        exp_manuf = '0; exp_model = '0; spi_miso = 1'b0;
        mb[0] = 0; mb[1] = 0; mb[2] = 0; mb[3] = 0; sig_v = 0; stat_v = 0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 cs_n", spi_cs_n, 1'b1);
        check("R10 sck", spi_sck, 1'b0);
        check("R10 done", done, 1'b0);
        check("R10 busy", busy, 1'b0);
        check("R10 match", {id_match, id_nomatch}, 2'b00);
        check("R10 flags", {parity_warn, legacy_used}, 2'b00);
        check("R10 ids", {manuf_id, model_id}, 32'h0);
        check("R10 status", status_byte, 8'h00);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R2 R4 R5 R7: sweep of byte0 in 3-byte mode, four verdict choices
        for (int v = 0; v < 256; v++) begin
            c1 = 8'(v) ^ 8'h5A;
            c2 = 8'(v + 3);
            compute_expect(8'(v), c1, c2, 8'h11, 1'b0, 16'h0, 16'h0, 8'h00, 8'h00);
            mm = e_manuf; md = e_model;
            case (v % 4)
                0: probe(8'(v), c1, c2, 8'h11, 1'b0, mm, md, 8'h00, 8'(v ^ 8'hC3), 0);
                1: probe(8'(v), c1, c2, 8'h11, 1'b0, mm, md ^ 16'h0001, 8'h00, 8'h3C, 0);
                2: probe(8'(v), c1, c2, 8'h11, 1'b0, mm, GEN, 8'h00, 8'(v), 0);
                default: probe(8'(v), c1, c2, 8'h11, 1'b0, mm ^ 16'h0100, md, 8'h00, 8'h77, 0);
            endcase
        end

        // R3 R4: sweep of byte1 behind the continuation code in 4-byte mode
        for (int v = 0; v < 256; v++) begin
            probe(8'h7F, 8'(v), 8'h25, 8'(v ^ 8'h81), 1'b1,
                  {8'h7F, 8'(v)}, {8'h25, 8'(v ^ 8'h81)}, 8'h00, 8'h9C, 0);
        end

        // R3 continuation in 3-byte mode, exact and wrong model
        probe(8'h7F, 8'h9D, 8'h46, 8'hEE, 1'b0, 16'h7F9D, 16'h0046, 8'h00, 8'h1C, 0);
        probe(8'h7F, 8'h9D, 8'h46, 8'hEE, 1'b0, 16'h7F9D, 16'h46EE, 8'h00, 8'h1C, 0);
        // R2 byte3 ignored in 4-byte mode without continuation
        probe(8'hC2, 8'h20, 8'h15, 8'hA5, 1'b1, 16'h00C2, 16'h2015, 8'h00, 8'h02, 0);
        // R6 fallback, match and no match, both lengths
        probe(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 16'h1234, 16'h0013, 8'h13, 8'h80, 0);
        probe(8'hFF, 8'hFF, 8'hFF, 8'h00, 1'b1, 16'h0000, 16'h0014, 8'h13, 8'h80, 0);
        // R6 wildcard does not apply to the fallback
        probe(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 16'h0000, GEN, 8'h42, 8'h80, 0);
        // R9 start during a probe is ignored
        probe(8'hBF, 8'h25, 8'h41, 8'h00, 1'b0, 16'h00BF, 16'h2541, 8'h00, 8'h1E, 1);

        finish_run();
    end
endmodule